// File: doc/BRIEF.md
# Constant-Gm Vector Modulator Slice Mapper

This block turns a requested complex weight into phase-select codes for a vector modulator made of identical current slices. Every slice is always connected to exactly one of four quadrature phases, so the number of active slices never depends on the weight. The slices are split into binary-weighted groups. Choosing one phase per group reaches every point of a square grid of equally spaced points, rotated 45 degrees from the I/Q axes.

A request is either a Cartesian weight (signed fixed-point I and Q) or a polar weight (a phase-step index plus an amplitude level). The block works in rotated coordinates a = I + Q and b = I - Q. It quantises each of them to the nearest odd grid level and pulls points that fall outside the largest inscribed circle back inside it. It then expands the per-group signs into one 2-bit code per slice. A per-request enable can switch an element's slices off, which removes the element from the summed output.

Top module: `vm_slice_mapper`

## Requirements
- R1: There are M = 2^N - 1 slices in N groups (N = 4, M = 15). Group k holds 2^k slices, at indices 2^k - 1 up to 2^(k+1) - 2. All slices of a group carry the same code. Slice j's code sits at `out_code[2j+1:2j]`.
- R2: A code maps to a sign pair (sa, sb) in rotated coordinates as follows: 00 (0 deg) = (+,+), 01 (90 deg) = (+,-), 10 (180 deg) = (-,-), 11 (270 deg) = (-,+). The reached point is A = sum over slices of sa and B = sum over slices of sb.
- R3: In Cartesian mode, I and Q are 10-bit two's complement values with 3 fractional bits, so one slice equals 8 LSB. The block computes a = I + Q and b = I - Q. Each axis is quantised to the odd level 2*floor(x/16) + 1, clamped to the range -15 to +15.
- R4: If A^2 + B^2 > 225 after quantisation, the coordinate with the larger magnitude (A on a tie) moves two steps toward zero. This repeats until the point lies inside the circle. No produced point has A^2 + B^2 > 225.
- R5: In polar mode, a step index p (6 bits) selects one of 44 equal phase steps, and indices of 44 or more are reduced by 44. The amplitude L is 4 bits. The block forms I = floor(L*C/16) and Q = floor(L*S/16), where C and S are round(84.85*cos(2*pi*p/44)) and round(84.85*sin(2*pi*p/44)). The result then passes through R3 and R4.
- R6: The enable captured with a request appears on `out_on`. When that enable is 0, every slice code is 00.
- R7: A request sampled at clock edge e gives its result and a one-cycle `out_done` pulse after edge e+1. Back-to-back requests are accepted on consecutive cycles. Between results, `out_on` and `out_code` hold their values.
- R8: After reset, `out_done` and `out_on` are 0 and all codes are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_polar | input | 1 | 1 = polar request, 0 = Cartesian |
| req_enable | input | 1 | Element enable for this request |
| req_i | input | 10 | Cartesian in-phase weight |
| req_q | input | 10 | Cartesian quadrature weight |
| req_step | input | 6 | Polar phase-step index |
| req_amp | input | 4 | Polar amplitude level |
| out_done | output | 1 | Result pulse |
| out_on | output | 1 | Element slices switched on |
| out_code | output | 30 | Two-bit phase code per slice |

## Verification
Circle clipping and element disable can hit the same request. A weight far outside the circle sent with the enable low must still give all-zero codes and `out_on` low. The same weight sent again enabled must then reach the clipped point. Back-to-back strobes make a new capture coincide with the previous result's done pulse, and each of the two results is judged in its own cycle. The reached point is rebuilt by summing the decoded signs of all slices and compared with the quantised and clipped target worked out from I and Q.

// File: rtl/vm_pkg.sv
package vm_pkg;

    localparam int VM_NGRP   = 4;
    localparam int VM_DW     = 10;
    localparam int VM_FRAC   = 3;
    localparam int VM_PSTEPS = 44;
    localparam int VM_ABITS  = 4;

    typedef enum logic [1:0] {
        PH0   = 2'b00,
        PH90  = 2'b01,
        PH180 = 2'b10,
        PH270 = 2'b11
    } phase_e;

    typedef struct packed {
        logic pos_a;
        logic pos_b;
    } sgn_pair_t;

    function automatic phase_e to_code(sgn_pair_t s);
        case ({s.pos_a, s.pos_b})
            2'b11:   return PH0;
            2'b10:   return PH90;
            2'b00:   return PH180;
            default: return PH270;
        endcase
    endfunction

    function automatic real taylor_cos(real x);
        real term = 1.0;
        real sum  = 1.0;
        for (int n = 1; n <= 9; n++) begin
            term = -term * x * x / ((2.0 * n - 1.0) * (2.0 * n));
            sum  = sum + term;
        end
        return sum;
    endfunction

    function automatic real taylor_sin(real x);
        real term = x;
        real sum  = x;
        for (int n = 1; n <= 9; n++) begin
            term = -term * x * x / ((2.0 * n) * (2.0 * n + 1.0));
            sum  = sum + term;
        end
        return sum;
    endfunction

    // Scaled cosine (want_sin = 0) or sine of 2*pi*p/k, rounded to integer.
    function automatic int trig_scaled(int p, int k, real rad, bit want_sin);
        int  quarter = k / 4;
        int  quad    = p / quarter;
        int  rem     = p % quarter;
        real x       = 2.0 * 3.141592653589793 * rem / k;
        real c       = taylor_cos(x);
        real s       = taylor_sin(x);
        real rc;
        real rs;
        case (quad)
            0:       begin rc =  c; rs =  s; end
            1:       begin rc = -s; rs =  c; end
            2:       begin rc = -c; rs = -s; end
            default: begin rc =  s; rs = -c; end
        endcase
        return want_sin ? int'(rad * rs) : int'(rad * rc);
    endfunction

endpackage

// File: rtl/vm_polar.sv
module vm_polar #(
    parameter int PSTEPS = vm_pkg::VM_PSTEPS,
    parameter int ABITS  = vm_pkg::VM_ABITS,
    parameter int DW     = vm_pkg::VM_DW,
    parameter int FRAC   = vm_pkg::VM_FRAC,
    parameter int NSLC   = 15,
    parameter int SW     = $clog2(PSTEPS)
) (
    input  logic [SW-1:0]        step,
    input  logic [ABITS-1:0]     amp,
    output logic signed [DW-1:0] pol_i,
    output logic signed [DW-1:0] pol_q
);
    localparam real RAD = NSLC * (2.0 ** FRAC) * 0.7071067811865476;
    localparam int  PW  = DW + ABITS + 1;

    logic signed [DW-1:0] cos_tab [PSTEPS];
    logic signed [DW-1:0] sin_tab [PSTEPS];

    for (genvar g = 0; g < PSTEPS; g++) begin : g_tab
        localparam int CV = vm_pkg::trig_scaled(g, PSTEPS, RAD, 1'b0);
        localparam int SV = vm_pkg::trig_scaled(g, PSTEPS, RAD, 1'b1);
        assign cos_tab[g] = DW'(CV);
        assign sin_tab[g] = DW'(SV);
    end

    logic [SW-1:0]        idx;
    logic signed [PW-1:0] amp_x, cx, sx, prod_i, prod_q;

    always_comb begin
        idx    = (step >= SW'(PSTEPS)) ? step - SW'(PSTEPS) : step;
        amp_x  = PW'($signed({1'b0, amp}));
        cx     = PW'(cos_tab[idx]);
        sx     = PW'(sin_tab[idx]);
        prod_i = amp_x * cx;
        prod_q = amp_x * sx;
        pol_i  = prod_i[ABITS+DW-1:ABITS];
        pol_q  = prod_q[ABITS+DW-1:ABITS];
    end
endmodule

// File: rtl/vm_axis_quant.sv
module vm_axis_quant #(
    parameter int DW   = vm_pkg::VM_DW,
    parameter int FRAC = vm_pkg::VM_FRAC,
    parameter int NGRP = vm_pkg::VM_NGRP,
    parameter int LW   = NGRP + 2
) (
    input  logic signed [DW:0]   axis_val,
    output logic signed [LW-1:0] level
);
    localparam logic signed [DW:0] QHI = (DW+1)'(2 ** (NGRP - 1) - 1);
    localparam logic signed [DW:0] QLO = -(DW+1)'(2 ** (NGRP - 1));

    logic signed [DW:0] q_raw, q_cl;

    always_comb begin
        q_raw = axis_val >>> (FRAC + 1);
        if (q_raw > QHI)      q_cl = QHI;
        else if (q_raw < QLO) q_cl = QLO;
        else                  q_cl = q_raw;
        level = {q_cl[LW-2:0], 1'b1};
    end
endmodule

// File: rtl/vm_circle_clip.sv
module vm_circle_clip #(
    parameter int NGRP = vm_pkg::VM_NGRP,
    parameter int NSLC = 2 ** NGRP - 1,
    parameter int LW   = NGRP + 2
) (
    input  logic signed [LW-1:0] in_a,
    input  logic signed [LW-1:0] in_b,
    output logic signed [LW-1:0] out_a,
    output logic signed [LW-1:0] out_b
);
    localparam int                   RW  = 2 * LW + 1;
    localparam logic signed [RW-1:0] LIM = RW'(NSLC * NSLC);
    localparam logic signed [LW-1:0] TWO = LW'(2);

    logic signed [LW-1:0] ca, cb, mag_a, mag_b;
    logic signed [RW-1:0] xa, xb;

    always_comb begin
        ca = in_a;
        cb = in_b;
        for (int it = 0; it < NSLC; it++) begin
            xa    = RW'(ca);
            xb    = RW'(cb);
            mag_a = ca[LW-1] ? -ca : ca;
            mag_b = cb[LW-1] ? -cb : cb;
            if (xa * xa + xb * xb > LIM) begin
                if (mag_a >= mag_b) ca = ca[LW-1] ? ca + TWO : ca - TWO;
                else                cb = cb[LW-1] ? cb + TWO : cb - TWO;
            end
        end
        out_a = ca;
        out_b = cb;
    end
endmodule

// File: rtl/vm_slice_map.sv
module vm_slice_map #(
    parameter int NGRP = vm_pkg::VM_NGRP,
    parameter int NSLC = 2 ** NGRP - 1
) (
    input  logic [NGRP-1:0]   pos_a,
    input  logic [NGRP-1:0]   pos_b,
    input  logic              on,
    output logic [2*NSLC-1:0] codes
);
    import vm_pkg::*;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        phase_e grp_code;
        assign grp_code = on ? to_code(sgn_pair_t'{pos_a: pos_a[g], pos_b: pos_b[g]}) : PH0;
        for (genvar j = 0; j < (1 << g); j++) begin : g_slc
            assign codes[2*((1 << g) - 1 + j) +: 2] = grp_code;
        end
    end
endmodule

// File: rtl/vm_slice_mapper.sv
module vm_slice_mapper #(
    parameter int NGRP   = vm_pkg::VM_NGRP,
    parameter int DW     = vm_pkg::VM_DW,
    parameter int FRAC   = vm_pkg::VM_FRAC,
    parameter int PSTEPS = vm_pkg::VM_PSTEPS,
    parameter int ABITS  = vm_pkg::VM_ABITS,
    parameter int NSLC   = 2 ** NGRP - 1,
    parameter int SW     = $clog2(PSTEPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_polar,
    input  logic                 req_enable,
    input  logic signed [DW-1:0] req_i,
    input  logic signed [DW-1:0] req_q,
    input  logic [SW-1:0]        req_step,
    input  logic [ABITS-1:0]     req_amp,
    output logic                 out_done,
    output logic                 out_on,
    output logic [2*NSLC-1:0]    out_code
);
    localparam int                   LW  = NGRP + 2;
    localparam logic signed [LW-1:0] OFS = LW'(NSLC);

    // capture stage
    logic                 s1_v, s1_polar, s1_en;
    logic signed [DW-1:0] s1_i, s1_q;
    logic [SW-1:0]        s1_step;
    logic [ABITS-1:0]     s1_amp;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v     <= 1'b0;
            s1_polar <= 1'b0;
            s1_en    <= 1'b0;
            s1_i     <= '0;
            s1_q     <= '0;
            s1_step  <= '0;
            s1_amp   <= '0;
        end else begin
            s1_v <= req_valid;
            if (req_valid) begin
                s1_polar <= req_polar;
                s1_en    <= req_enable;
                s1_i     <= req_i;
                s1_q     <= req_q;
                s1_step  <= req_step;
                s1_amp   <= req_amp;
            end
        end
    end

    // weight selection and rotation
    logic signed [DW-1:0] pol_i, pol_q, sel_i, sel_q;
    logic signed [DW:0]   rot_a, rot_b;

    vm_polar #(.PSTEPS(PSTEPS), .ABITS(ABITS), .DW(DW), .FRAC(FRAC), .NSLC(NSLC), .SW(SW)) u_polar (
        .step (s1_step),
        .amp  (s1_amp),
        .pol_i(pol_i),
        .pol_q(pol_q)
    );

    always_comb begin
        sel_i = s1_polar ? pol_i : s1_i;
        sel_q = s1_polar ? pol_q : s1_q;
        rot_a = {sel_i[DW-1], sel_i} + {sel_q[DW-1], sel_q};
        rot_b = {sel_i[DW-1], sel_i} - {sel_q[DW-1], sel_q};
    end

    // quantise and clip
    logic signed [LW-1:0] lvl_a, lvl_b, clp_a, clp_b, sum_a, sum_b;

    vm_axis_quant #(.DW(DW), .FRAC(FRAC), .NGRP(NGRP), .LW(LW)) u_qa (.axis_val(rot_a), .level(lvl_a));
    vm_axis_quant #(.DW(DW), .FRAC(FRAC), .NGRP(NGRP), .LW(LW)) u_qb (.axis_val(rot_b), .level(lvl_b));

    vm_circle_clip #(.NGRP(NGRP), .NSLC(NSLC), .LW(LW)) u_clip (
        .in_a (lvl_a),
        .in_b (lvl_b),
        .out_a(clp_a),
        .out_b(clp_b)
    );

    // level to per-group sign bits: u = (level + M) / 2
    logic [2*NSLC-1:0] map_code;

    always_comb begin
        sum_a = clp_a + OFS;
        sum_b = clp_b + OFS;
    end

    vm_slice_map #(.NGRP(NGRP), .NSLC(NSLC)) u_map (
        .pos_a(sum_a[NGRP:1]),
        .pos_b(sum_b[NGRP:1]),
        .on   (s1_en),
        .codes(map_code)
    );

    // output stage
    always_ff @(posedge clk) begin
        if (rst) begin
            out_done <= 1'b0;
            out_on   <= 1'b0;
            out_code <= '0;
        end else begin
            out_done <= s1_v;
            if (s1_v) begin
                out_on   <= s1_en;
                out_code <= map_code;
            end
        end
    end

    // assertions
    localparam int RW = 2 * LW + 1;
    logic signed [RW-1:0] chk_a, chk_b;
    assign chk_a = RW'(clp_a);
    assign chk_b = RW'(clp_b);

    p_odd_levels_r3: assert property (@(posedge clk) disable iff (rst)
        s1_v |-> (clp_a[0] && clp_b[0]));

    p_in_circle_r4: assert property (@(posedge clk) disable iff (rst)
        s1_v |-> (chk_a * chk_a + chk_b * chk_b <= RW'(NSLC * NSLC)));

    p_enable_follow_r6: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_on == $past(req_enable, 2)));

    p_off_codes_r6: assert property (@(posedge clk) disable iff (rst)
        !out_on |-> (out_code == '0));

    p_done_latency_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid, 2) && !$past(rst) && !$past(rst, 2)) |-> out_done);

    p_done_source_r7: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(req_valid, 2));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_code) && $stable(out_on)));

    p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_done && !out_on && out_code == '0));
endmodule

// File: tb/sim_vm_slice_mapper.sv
module sim_vm_slice_mapper;
    localparam int NG = 4;
    localparam int NS = 15;
    localparam int K  = 44;
    localparam real RADQ = 15.0 * 8.0 * 0.7071067811865476;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_polar = 1'b0, req_enable = 1'b0;
    logic signed [9:0] req_i = '0, req_q = '0;
    logic [5:0]  req_step = '0;
    logic [3:0]  req_amp = '0;
    logic        out_done, out_on;
    logic [29:0] out_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    vm_slice_mapper u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_polar(req_polar),
        .req_enable(req_enable), .req_i(req_i), .req_q(req_q),
        .req_step(req_step), .req_amp(req_amp),
        .out_done(out_done), .out_on(out_on), .out_code(out_code)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R3 / R4 model
    function automatic void model_iq(input int i, input int q, output int ea, output int eb);
        int a = i + q;
        int b = i - q;
        int qa = a >>> 4;
        int qb = b >>> 4;
        if (qa > 7) qa = 7;
        if (qa < -8) qa = -8;
        if (qb > 7) qb = 7;
        if (qb < -8) qb = -8;
        ea = 2 * qa + 1;
        eb = 2 * qb + 1;
        while (ea * ea + eb * eb > NS * NS) begin
            if ((ea < 0 ? -ea : ea) >= (eb < 0 ? -eb : eb)) ea = (ea < 0) ? ea + 2 : ea - 2;
            else eb = (eb < 0) ? eb + 2 : eb - 2;
        end
    endfunction

    // R5 model
    function automatic void model_polar(input int p, input int l, output int i, output int q);
        int  idx = (p >= K) ? p - K : p;
        real ang = 2.0 * 3.141592653589793 * idx / K;
        int  c = int'(RADQ * $cos(ang));
        int  s = int'(RADQ * $sin(ang));
        i = (l * c) >>> 4;
        q = (l * s) >>> 4;
    endfunction

    // R1 / R2: rebuild point from slice codes
    task automatic judge(input string req, input int ea, input int eb, input bit en);
        int sa = 0;
        int sb = 0;
        int uni = 1;
        check(req, "done pulse (R7)", int'(out_done), 1);
        check(req, "element on (R6)", int'(out_on), int'(en));
        if (!en) begin
            check(req, "codes zero when off (R6)", int'(out_code == '0), 1);
        end else begin
            for (int k = 0; k < NG; k++) begin
                logic [1:0] gc = out_code[2*((1 << k) - 1) +: 2];
                for (int j = 0; j < (1 << k); j++) begin
                    logic [1:0] c = out_code[2*((1 << k) - 1 + j) +: 2];
                    if (c != gc) uni = 0;
                    case (c)
                        2'b00: begin sa += 1; sb += 1; end
                        2'b01: begin sa += 1; sb -= 1; end
                        2'b10: begin sa -= 1; sb -= 1; end
                        default: begin sa -= 1; sb += 1; end
                    endcase
                end
            end
            check(req, "group codes uniform (R1)", uni, 1);
            check(req, "rebuilt A (R2)", sa, ea);
            check(req, "rebuilt B (R2)", sb, eb);
            check(req, "inside circle (R4)", int'(sa * sa + sb * sb <= NS * NS), 1);
        end
    endtask

    task automatic drive(input bit pol, input bit en, input int i, input int q, input int p, input int l);
        req_valid  = 1'b1;
        req_polar  = pol;
        req_enable = en;
        req_i      = 10'(i);
        req_q      = 10'(q);
        req_step   = 6'(p);
        req_amp    = 4'(l);
    endtask

    task automatic run_iq(input string req, input int i, input int q, input bit en);
        int ea, eb;
        model_iq(i, q, ea, eb);
        @(negedge clk);
        drive(1'b0, en, i, q, 0, 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "no early done (R7)", int'(out_done), 0);
        @(posedge clk);
        @(negedge clk);
        judge(req, ea, eb, en);
    endtask

    task automatic run_polar(input string req, input int p, input int l);
        int i, q, ea, eb;
        model_polar(p, l, i, q);
        model_iq(i, q, ea, eb);
        @(negedge clk);
        drive(1'b1, 1'b1, 0, 0, p, l);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        judge(req, ea, eb, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check("R8", "done after reset", int'(out_done), 0);
        check("R8", "on after reset", int'(out_on), 0);
        check("R8", "codes after reset", int'(out_code == '0), 1);

        // directed Cartesian corners
        run_iq("R3", 0, 0, 1'b1);
        run_iq("R3", -1, 0, 1'b1);
        run_iq("R3", 15, 1, 1'b1);
        run_iq("R4", 500, 0, 1'b1);
        run_iq("R4", -512, -512, 1'b1);
        run_iq("R4", 100, -90, 1'b1);
        run_iq("R6", 500, 0, 1'b0);
        run_iq("R6", 500, 0, 1'b1);

        // directed polar: 90 deg, wrap, zero amplitude
        run_polar("R5", 11, 15);
        run_polar("R5", 50, 9);
        run_polar("R5", 0, 0);
        run_polar("R5", 33, 15);

        // R7 back-to-back and hold
        begin
            int a1, b1, a2, b2;
            model_iq(40, 8, a1, b1);
            model_iq(-70, 30, a2, b2);
            @(negedge clk);
            drive(1'b0, 1'b1, 40, 8, 0, 0);
            @(posedge clk);
            @(negedge clk);
            drive(1'b0, 1'b1, -70, 30, 0, 0);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            judge("R7", a1, b1, 1'b1);
            @(posedge clk);
            @(negedge clk);
            judge("R7", a2, b2, 1'b1);
            @(posedge clk);
            @(negedge clk);
            check("R7", "done drops", int'(out_done), 0);
            @(posedge clk);
            @(negedge clk);
            judge_hold: begin
                int sa = 0;
                for (int j = 0; j < NS; j++)
                    sa += out_code[2*j+1] ? -1 : 1;
                check("R7", "held A", sa, a2);
            end
        end

        // random mix
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 3) == 0)
                run_polar("R5", int'($urandom_range(0, 63)), int'($urandom_range(0, 15)));
            else
                run_iq("R3", int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512,
                       $urandom_range(0, 7) != 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule